// File: doc/BRIEF.md
# Instruction Trace Interrupt Unit

This unit sits next to the execute stage of a 64-bit core and produces single-step and branch-trace interrupts. Each cycle it sees the completion information of the instruction in execute: a valid strobe, a small instruction class code, and flags marking a branch or a return-from-interrupt. It also sees the current machine state word and the instruction address. When a completing instruction qualifies under the enabled trace mode, the unit arms itself.

While armed, the next valid instruction is not executed. In that cycle the unit raises a trace request. The request wins over any asynchronous interrupt that is pending in the same cycle. With the request the unit supplies the vector address, the saved-status bits, the return address (the suppressed instruction's address) and the next machine state word.

The saved-status word marks whether the traced instruction read or wrote memory, or behaves as if it did. The armed state is dropped only when the interrupt sequencer reports that its status write has completed.

Top module: `trace_irq_unit`

## Requirements
- R1: Reset state. After reset the unit is not armed, so a valid instruction raises no trace request (`trace_fire` low).
- R2: Single-step arming. With state-word bit 10 set, any valid completing instruction other than return-from-interrupt arms the unit. The next valid instruction then raises `trace_fire`.
- R3: Return-from-interrupt (`in_rfi` high) never arms the unit, whatever the trace bits and the branch flag are.
- R4: Branch-trace arming. With state-word bit 9 set, a valid instruction flagged as a branch arms the unit. With only bit 9 set, an instruction that is not a branch does not arm it.
- R5: Firing. `trace_fire` equals `in_valid` while armed. The armed state survives cycles without a valid instruction. `vec_addr` is 0x0D00 while firing.
- R6: Priority. `ext_irq_take` follows `ext_irq_req` on valid cycles, except that it is forced low in any cycle where `trace_fire` is high.
- R7: Saved status always has bit 30 set (LSB numbering) during a trace request.
- R8: Saved-status bit 28 is also set when the traced instruction was load-like. The load-like class codes are 1 (load), 3 (icache invalidate), 4 (icache touch), 5 (dcache touch), 6 (dcache store) and 7 (dcache flush).
- R9: Saved-status bit 27 is also set when the traced instruction was store-like. The store-like class codes are 2 (store), 8 (dcache zero) and 9 (dcache touch for store). Codes 0 and 10 to 15 set neither bit 28 nor bit 27.
- R10: The saved-status load and store bits come from the traced instruction, not from the suppressed one. `save_pc` equals `pc_in` of the suppressed instruction.
- R11: `msr_next` equals `msr_in` with bits 10, 9, 15, 14, 5, 4 and 1 cleared and bits 63 and 0 set.
- R12: `status_done` clears the armed state at the next edge and overrides an arming in the same cycle. After that, a valid instruction raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction in execute is valid this cycle |
| in_class | input | 4 | Instruction class code |
| in_branch | input | 1 | Instruction is a branch (any form) |
| in_rfi | input | 1 | Instruction is return-from-interrupt |
| msr_in | input | 64 | Current machine state word |
| pc_in | input | 64 | Address of the instruction in execute |
| ext_irq_req | input | 1 | An asynchronous interrupt is pending |
| status_done | input | 1 | Interrupt status write has completed |
| trace_fire | output | 1 | Suppress this instruction and take a trace interrupt |
| ext_irq_take | output | 1 | Asynchronous interrupt may be taken this cycle |
| vec_addr | output | 64 | Trace interrupt vector |
| status_bits | output | 64 | Saved-status bits to write |
| save_pc | output | 64 | Return address to save |
| msr_next | output | 64 | Machine state word on interrupt entry |

## Verification
The assertions check the following on every cycle:
- a request only appears with a valid instruction;
- the asynchronous take is never granted together with a request;
- `status_done` always drops the armed state;
- arming only follows a valid, non-return instruction;
- the status word carries the trace bit and at most one of the load and store bits;
- the entry state word always has both trace bits cleared.

Only the bench's scenarios can show the rest:
- which combinations of trace mode, branch flag and return flag arm the unit;
- that the load or store tag follows the traced instruction's class rather than the suppressed one's;
- that arming persists across idle cycles;
- that `status_done` wins over a simultaneous arming.

// File: rtl/trace_pkg.sv
package trace_pkg;

    localparam int XLEN = 64;

    typedef enum logic [3:0] {
        CLS_OTHER  = 4'd0,
        CLS_LOAD   = 4'd1,
        CLS_STORE  = 4'd2,
        CLS_ICINV  = 4'd3,
        CLS_ICTCH  = 4'd4,
        CLS_DCTCH  = 4'd5,
        CLS_DCSTO  = 4'd6,
        CLS_DCFLS  = 4'd7,
        CLS_DCZRO  = 4'd8,
        CLS_DCTST  = 4'd9
    } insn_class_e;

    typedef struct packed {
        logic load_like;
        logic store_like;
    } mem_kind_t;

    // machine state word bit positions (LSB numbering)
    localparam int ST_STEP  = 10;
    localparam int ST_BRTR  = 9;
    localparam int ST_EXTEN = 15;
    localparam int ST_PROB  = 14;
    localparam int ST_IREL  = 5;
    localparam int ST_DREL  = 4;
    localparam int ST_RECOV = 1;
    localparam int ST_WIDE  = 63;
    localparam int ST_LITTLE = 0;

    // saved-status bit positions (LSB numbering)
    localparam int SS_TRACE = 30;
    localparam int SS_LOAD  = 28;
    localparam int SS_STORE = 27;

    localparam int N_CLR = 7;
    localparam int CLR_POS [N_CLR] = '{ST_STEP, ST_BRTR, ST_EXTEN, ST_PROB,
                                       ST_IREL, ST_DREL, ST_RECOV};

    function automatic mem_kind_t classify(input logic [3:0] code);
        mem_kind_t k;
        k.load_like  = 1'b0;
        k.store_like = 1'b0;
        case (code)
            CLS_LOAD, CLS_ICINV, CLS_ICTCH,
            CLS_DCTCH, CLS_DCSTO, CLS_DCFLS: k.load_like  = 1'b1;
            CLS_STORE, CLS_DCZRO, CLS_DCTST: k.store_like = 1'b1;
            default: ;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/trace_arm.sv
module trace_arm
    import trace_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [3:0]  in_class,
    input  logic        in_branch,
    input  logic        in_rfi,
    input  logic        step_en,
    input  logic        brtr_en,
    input  logic        status_done,
    output logic        armed,
    output logic        fire,
    output mem_kind_t   kind_q
);
    logic arm_now;

    assign fire    = in_valid & armed;
    assign arm_now = in_valid & ~armed & ~in_rfi &
                     (step_en | (brtr_en & in_branch));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            kind_q <= '0;
        end else begin
            if (status_done)
                armed <= 1'b0;
            else if (arm_now)
                armed <= 1'b1;
            if (in_valid && !armed)
                kind_q <= classify(in_class);
        end
    end

    // R12
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        status_done |=> !armed);

    // R3
    arm_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(in_valid && !in_rfi));

    // R5
    fire_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> in_valid);

endmodule

// File: rtl/trace_status.sv
module trace_status
    import trace_pkg::*;
#(
    parameter logic [XLEN-1:0] VECTOR = 64'h0000_0000_0000_0D00
)(
    input  mem_kind_t        kind_q,
    input  logic [XLEN-1:0]  pc_in,
    input  logic [XLEN-1:0]  msr_in,
    output logic [XLEN-1:0]  vec_addr,
    output logic [XLEN-1:0]  status_bits,
    output logic [XLEN-1:0]  save_pc,
    output logic [XLEN-1:0]  msr_next
);
    logic [XLEN-1:0] clr_mask;
    logic [XLEN-1:0] set_mask;

    for (genvar g = 0; g < XLEN; g++) begin : g_mask
        localparam bit IS_CLR = (g == CLR_POS[0]) || (g == CLR_POS[1]) ||
                                (g == CLR_POS[2]) || (g == CLR_POS[3]) ||
                                (g == CLR_POS[4]) || (g == CLR_POS[5]) ||
                                (g == CLR_POS[6]);
        assign clr_mask[g] = IS_CLR;
        assign set_mask[g] = (g == ST_WIDE) || (g == ST_LITTLE);
    end

    always_comb begin
        status_bits           = '0;
        status_bits[SS_TRACE] = 1'b1;
        status_bits[SS_LOAD]  = kind_q.load_like;
        status_bits[SS_STORE] = kind_q.store_like;
    end

    assign vec_addr = VECTOR;
    assign save_pc  = pc_in;
    assign msr_next = (msr_in & ~clr_mask) | set_mask;

endmodule

// File: rtl/trace_irq_unit.sv
module trace_irq_unit
    import trace_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [3:0]  in_class,
    input  logic        in_branch,
    input  logic        in_rfi,
    input  logic [63:0] msr_in,
    input  logic [63:0] pc_in,
    input  logic        ext_irq_req,
    input  logic        status_done,
    output logic        trace_fire,
    output logic        ext_irq_take,
    output logic [63:0] vec_addr,
    output logic [63:0] status_bits,
    output logic [63:0] save_pc,
    output logic [63:0] msr_next
);
    logic      armed;
    mem_kind_t kind_q;

    trace_arm u_arm (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_class    (in_class),
        .in_branch   (in_branch),
        .in_rfi      (in_rfi),
        .step_en     (msr_in[ST_STEP]),
        .brtr_en     (msr_in[ST_BRTR]),
        .status_done (status_done),
        .armed       (armed),
        .fire        (trace_fire),
        .kind_q      (kind_q)
    );

    trace_status u_stat (
        .kind_q      (kind_q),
        .pc_in       (pc_in),
        .msr_in      (msr_in),
        .vec_addr    (vec_addr),
        .status_bits (status_bits),
        .save_pc     (save_pc),
        .msr_next    (msr_next)
    );

    assign ext_irq_take = ext_irq_req & in_valid & ~trace_fire;

    // R6
    trace_beats_async_chk: assert property (@(posedge clk) disable iff (rst)
        trace_fire |-> !ext_irq_take);

    // R7
    trace_bit_chk: assert property (@(posedge clk) disable iff (rst)
        trace_fire |-> status_bits[SS_TRACE]);

    // R8 R9
    kind_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(status_bits[SS_LOAD -: 2]));

    // R11
    entry_state_chk: assert property (@(posedge clk) disable iff (rst)
        trace_fire |-> (!msr_next[ST_STEP] && !msr_next[ST_BRTR] && msr_next[ST_WIDE]));

endmodule

// File: tb/trace_irq_unit_tb.sv
module trace_irq_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  in_class;
    logic        in_branch;
    logic        in_rfi;
    logic [63:0] msr_in;
    logic [63:0] pc_in;
    logic        ext_irq_req;
    logic        status_done;
    logic        trace_fire;
    logic        ext_irq_take;
    logic [63:0] vec_addr;
    logic [63:0] status_bits;
    logic [63:0] save_pc;
    logic [63:0] msr_next;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    trace_irq_unit u_dut (.*);

    localparam logic [63:0] STEP = 64'h400;
    localparam logic [63:0] BRTR = 64'h200;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_status(input int c);
        logic [63:0] s = 64'h4000_0000;
        if (c == 1 || (c >= 3 && c <= 7)) s |= 64'h1000_0000;
        if (c == 2 || c == 8 || c == 9)   s |= 64'h0800_0000;
        return s;
    endfunction

    function automatic logic [63:0] exp_msr(input logic [63:0] m);
        logic [63:0] r = m;
        r[10] = 0; r[9] = 0; r[15] = 0; r[14] = 0; r[5] = 0; r[4] = 0; r[1] = 0;
        r[63] = 1; r[0] = 1;
        return r;
    endfunction

    task automatic idle_inputs();
        in_valid = 0; in_class = 0; in_branch = 0; in_rfi = 0;
        msr_in = 0; pc_in = 0; ext_irq_req = 0; status_done = 0;
    endtask

    task automatic drive(input logic [3:0] c, input logic br, input logic rf,
                         input logic [63:0] m, input logic [63:0] pc);
        in_valid = 1; in_class = c; in_branch = br; in_rfi = rf;
        msr_in = m; pc_in = pc;
    endtask

    task automatic clear_done();
        @(negedge clk); idle_inputs(); status_done = 1;
        @(negedge clk); status_done = 0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        drive(4'd0, 0, 0, 64'h0, 64'h100);
        #1 chk("R1 no fire after reset", {63'd0, trace_fire}, 64'd0);

        // Sweep: class x step x branch-trace x branch x rfi
        for (int i = 0; i < 256; i++) begin
            logic [3:0] c = i[3:0];
            logic st = i[4], bt = i[5], br = i[6], rf = i[7];
            logic exp_fire = !rf && (st || (bt && br));
            logic [63:0] m2 = 64'hA5A5_3C3C_0F0F_9696 ^ {32'(i), 32'(i * 7)};
            logic [63:0] pc2 = 64'h0000_1000_0000_0000 + 64'(i * 8);
            @(negedge clk);
            drive(c, br, rf, (st ? STEP : 64'd0) | (bt ? BRTR : 64'd0), pc2 - 4);
            @(negedge clk);
            if (!exp_fire) m2 = m2 & ~(STEP | BRTR);
            drive(4'(int'(c) + 5), 0, 0, m2, pc2);
            ext_irq_req = 1;
            #1;
            // R2 R3 R4 arming outcome
            chk($sformatf("R2/R3/R4 fire cls=%0d st=%0b bt=%0b br=%0b rf=%0b", c, st, bt, br, rf),
                {63'd0, trace_fire}, {63'd0, exp_fire});
            if (exp_fire) begin
                chk("R5 vector", vec_addr, 64'hD00);
                chk("R6 async blocked", {63'd0, ext_irq_take}, 64'd0);
                chk($sformatf("R7 R8 R9 status cls=%0d", c), status_bits, exp_status(int'(c)));
                chk("R10 save_pc", save_pc, pc2);
                chk("R11 msr_next", msr_next, exp_msr(m2));
            end else begin
                chk("R6 async taken", {63'd0, ext_irq_take}, 64'd1);
            end
            clear_done();
            drive(4'd0, 0, 0, 64'd0, 64'h40);
            #1 chk("R12 cleared after done", {63'd0, trace_fire}, 64'd0);
        end

        // R5 armed state persists through idle cycles
        @(negedge clk); drive(4'd2, 0, 0, STEP, 64'h200);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); idle_inputs();
            #1 chk("R5 no fire without valid", {63'd0, trace_fire}, 64'd0);
        end
        @(negedge clk); drive(4'd1, 0, 0, 64'd0, 64'h204);
        #1 chk("R5 fire after idle", {63'd0, trace_fire}, 64'd1);
        chk("R10 traced store class kept", status_bits, 64'h4800_0000);
        clear_done();

        // R12 done overrides same-cycle arming
        @(negedge clk); drive(4'd0, 1, 0, STEP | BRTR, 64'h300); status_done = 1;
        @(negedge clk); status_done = 0; drive(4'd0, 0, 0, 64'd0, 64'h304);
        #1 chk("R12 done beats arm", {63'd0, trace_fire}, 64'd0);

        // R4 branch trace alone ignores non-branch
        @(negedge clk); drive(4'd1, 0, 0, BRTR, 64'h400);
        @(negedge clk); drive(4'd0, 0, 0, 64'd0, 64'h404);
        #1 chk("R4 non-branch not armed", {63'd0, trace_fire}, 64'd0);

        @(negedge clk); idle_inputs();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule